// File: doc/BRIEF.md
# Hashed Auxiliary Match Table

This block sits at one level of a pipelined multi-field string matcher. Each character is split into several narrow bit-fields. A separate partial state machine walks each field and, at this level, produces one state number and a flag that says whether the state is a partial-match state. The block merges those per-field results into one full-pattern verdict. When every field reports a partial match, the state numbers are folded together by XOR into a table index. The entry at that index is read, and its stored tuple of per-field states is compared against the incoming tuple. If the tuples agree and the entry is valid, the block reports the full-match identifier held in the entry.

The match verdict is registered, so it moves one cycle behind its inputs, exactly as the state numbers move between levels. A match that arrives from the previous level is delayed through the same register. When this level finds a match in the same cycle, the local identifier replaces the arriving one, because a match at the deeper level implies the shorter one. The table is filled through a synchronous write port. It has one entry per possible index, which leaves room to spare for a dictionary that uses about two thirds of the slots or fewer.

Top module: `aux_match_merge`

## Requirements
- R1: While reset is low, and at the first output after reset, `match_vld_o` is 0 and `match_id_o` is 0. Reset marks every table entry invalid, so no lookup hits until an entry has been written.
- R2: A lookup can hit only when all NUM_FIELDS bits of `lkp_pm_i` are 1. If any bit is 0, no local match is reported, even when the table holds the incoming tuple.
- R3: The table index is the bitwise XOR of the NUM_FIELDS state numbers. Field i occupies bits [i*STATE_W +: STATE_W] of `lkp_state_i` and of `wr_states_i`.
- R4: A local hit requires the indexed entry to be valid and every stored field state to equal the incoming one. The hit's identifier appears on `match_id_o`, with `match_vld_o` = 1, one clock cycle after the inputs are presented.
- R5: When the indexed entry is invalid, or its stored tuple differs in any field, there is no local match. With `prev_vld_i` low, the output is then `match_vld_o` = 0 and `match_id_o` = 0.
- R6: When a local hit and `prev_vld_i` = 1 occur in the same cycle, the output carries the local identifier and the previous-level identifier is dropped.
- R7: Without a local hit, `prev_vld_i` and `prev_id_i` appear unchanged on `match_vld_o` and `match_id_o` one cycle later.
- R8: With `wr_en_i` = 1, the entry at `wr_addr_i` takes `wr_valid_i`, `wr_states_i` and `wr_id_i` at the clock edge. A lookup in that same cycle sees the old contents. Writing `wr_valid_i` = 0 removes the entry from all later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_state_i | input | NUM_FIELDS*STATE_W | Per-field state numbers at this level |
| lkp_pm_i | input | NUM_FIELDS | Per-field partial-match flags |
| prev_vld_i | input | 1 | Match arriving from the previous level |
| prev_id_i | input | ID_W | Identifier of the arriving match |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | STATE_W | Entry to write |
| wr_valid_i | input | 1 | Valid bit to store |
| wr_states_i | input | NUM_FIELDS*STATE_W | Field-state tuple to store |
| wr_id_i | input | ID_W | Full-match identifier to store |
| match_vld_o | output | 1 | Registered match valid |
| match_id_o | output | ID_W | Registered match identifier, 0 when not valid |

## Verification
The hardest case to reach is a tag mismatch on a valid entry. It needs a second tuple whose XOR lands on the same index as a stored tuple but differs in its fields. The bench builds one by swapping two field values of a stored tuple, which keeps the XOR the same, and drives it both alone and together with an arriving previous-level match. The stimulus also checks the boundary of the write port. It writes and looks up the same tuple in the same cycle, then invalidates an entry and looks that entry up again.

// File: rtl/amm_pkg.sv
package amm_pkg;
    localparam int AMM_FIELDS  = 3;
    localparam int AMM_STATE_W = 4;
    localparam int AMM_ID_W    = 6;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_PREV  = 2'd1,
        SRC_LOCAL = 2'd2
    } amm_src_e;
endpackage

// File: rtl/amm_hash.sv
module amm_hash #(
    parameter int FIELDS  = 3,
    parameter int STATE_W = 4
) (
    input  logic [FIELDS*STATE_W-1:0] states_i,
    output logic [STATE_W-1:0]        index_o
);
    always_comb begin
        index_o = '0;
        for (int i = 0; i < FIELDS; i++) begin
            index_o = index_o ^ states_i[i*STATE_W +: STATE_W];
        end
    end
endmodule

// File: rtl/amm_table.sv
module amm_table #(
    parameter int ADDR_W  = 4,
    parameter int ENTRY_W = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [ENTRY_W-1:0] rd_entry_o,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [ENTRY_W-1:0] wr_entry_i
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ENTRY_W-1:0] mem_d [DEPTH];
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en_i) begin
            mem_d[wr_addr_i] = wr_entry_i;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else begin
                    mem_q[g] <= mem_d[g];
                end
            end
        end
    endgenerate

    assign rd_entry_o = mem_q[rd_addr_i];
endmodule

// File: rtl/amm_compare.sv
module amm_compare #(
    parameter int FIELDS  = 3,
    parameter int STATE_W = 4,
    parameter int ID_W    = 6
) (
    input  logic [FIELDS*STATE_W-1:0]        states_i,
    input  logic [FIELDS-1:0]                pm_i,
    input  logic [1+ID_W+FIELDS*STATE_W-1:0] entry_i,
    output logic                             hit_o,
    output logic [ID_W-1:0]                  id_o
);
    localparam int TAG_W = FIELDS * STATE_W;

    logic            ent_valid;
    logic [ID_W-1:0] ent_id;
    logic [TAG_W-1:0] ent_tag;

    always_comb begin
        {ent_valid, ent_id, ent_tag} = entry_i;
        hit_o = (&pm_i) && ent_valid && (ent_tag == states_i);
        id_o  = ent_id;
    end
endmodule

// File: rtl/aux_match_merge.sv
module aux_match_merge
    import amm_pkg::*;
#(
    parameter int NUM_FIELDS = AMM_FIELDS,
    parameter int STATE_W    = AMM_STATE_W,
    parameter int ID_W       = AMM_ID_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_FIELDS*STATE_W-1:0] lkp_state_i,
    input  logic [NUM_FIELDS-1:0]         lkp_pm_i,
    input  logic                          prev_vld_i,
    input  logic [ID_W-1:0]               prev_id_i,
    input  logic                          wr_en_i,
    input  logic [STATE_W-1:0]            wr_addr_i,
    input  logic                          wr_valid_i,
    input  logic [NUM_FIELDS*STATE_W-1:0] wr_states_i,
    input  logic [ID_W-1:0]               wr_id_i,
    output logic                          match_vld_o,
    output logic [ID_W-1:0]               match_id_o
);
    localparam int TAG_W   = NUM_FIELDS * STATE_W;
    localparam int ENTRY_W = 1 + ID_W + TAG_W;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
    } out_t;

    logic [STATE_W-1:0] lkp_index;
    logic [ENTRY_W-1:0] rd_entry;
    logic [ENTRY_W-1:0] wr_entry;
    logic               local_hit;
    logic [ID_W-1:0]    local_id;
    amm_src_e           src;
    out_t               out_d, out_q;

    assign wr_entry = {wr_valid_i, wr_id_i, wr_states_i};

    amm_hash #(.FIELDS(NUM_FIELDS), .STATE_W(STATE_W)) u_hash (
        .states_i (lkp_state_i),
        .index_o  (lkp_index)
    );

    amm_table #(.ADDR_W(STATE_W), .ENTRY_W(ENTRY_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr_i  (lkp_index),
        .rd_entry_o (rd_entry),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_entry_i (wr_entry)
    );

    amm_compare #(.FIELDS(NUM_FIELDS), .STATE_W(STATE_W), .ID_W(ID_W)) u_cmp (
        .states_i (lkp_state_i),
        .pm_i     (lkp_pm_i),
        .entry_i  (rd_entry),
        .hit_o    (local_hit),
        .id_o     (local_id)
    );

    // Deeper (local) match implies the shorter arriving one, so it wins.
    always_comb begin
        if (local_hit)       src = SRC_LOCAL;
        else if (prev_vld_i) src = SRC_PREV;
        else                 src = SRC_NONE;

        out_d = '0;
        case (src)
            SRC_LOCAL: begin out_d.vld = 1'b1; out_d.id = local_id;  end
            SRC_PREV:  begin out_d.vld = 1'b1; out_d.id = prev_id_i; end
            default:   out_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign match_vld_o = out_q.vld;
    assign match_id_o  = out_q.id;
endmodule

// File: rtl/amm_checker.sv
module amm_checker #(
    parameter int FIELDS = 3,
    parameter int ID_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FIELDS-1:0] pm,
    input logic              prev_vld,
    input logic [ID_W-1:0]   prev_id,
    input logic              hit,
    input logic [ID_W-1:0]   hit_id,
    input logic              out_vld,
    input logic [ID_W-1:0]   out_id
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!out_vld && out_id == '0);
        end
    end

    // R2
    hit_needs_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (&pm));

    // R6
    local_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (out_vld && out_id == $past(hit_id)));

    // R7
    prev_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_vld && !hit) |=> (out_vld && out_id == $past(prev_id)));

    // R5
    no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_vld && !hit) |=> (!out_vld && out_id == '0));
endmodule

bind aux_match_merge amm_checker #(.FIELDS(NUM_FIELDS), .ID_W(ID_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pm       (lkp_pm_i),
    .prev_vld (prev_vld_i),
    .prev_id  (prev_id_i),
    .hit      (local_hit),
    .hit_id   (local_id),
    .out_vld  (match_vld_o),
    .out_id   (match_id_o)
);

// File: tb/aux_match_merge_bench.sv
module aux_match_merge_bench;
    localparam int K  = 3;
    localparam int S  = 4;
    localparam int IW = 6;
    localparam int DEPTH = 1 << S;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [K*S-1:0] lkp_state = '0;
    logic [K-1:0]   lkp_pm = '0;
    logic           prev_vld = 1'b0;
    logic [IW-1:0]  prev_id = '0;
    logic           wr_en = 1'b0;
    logic [S-1:0]   wr_addr = '0;
    logic           wr_valid = 1'b0;
    logic [K*S-1:0] wr_states = '0;
    logic [IW-1:0]  wr_id = '0;
    logic           match_vld;
    logic [IW-1:0]  match_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic           exp_vld_q [$];
    logic [IW-1:0]  exp_id_q  [$];
    string          req_q     [$];

    logic           m_valid  [DEPTH];
    logic [K*S-1:0] m_states [DEPTH];
    logic [IW-1:0]  m_id     [DEPTH];

    always #2.5 clk = ~clk;

    aux_match_merge u_aux_match_merge (
        .clk(clk), .rst_n(rst_n),
        .lkp_state_i(lkp_state), .lkp_pm_i(lkp_pm),
        .prev_vld_i(prev_vld), .prev_id_i(prev_id),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_valid_i(wr_valid),
        .wr_states_i(wr_states), .wr_id_i(wr_id),
        .match_vld_o(match_vld), .match_id_o(match_id)
    );

    function automatic logic [K*S-1:0] tup(input int a, input int b, input int c);
        return {c[S-1:0], b[S-1:0], a[S-1:0]};
    endfunction

    // Drive one cycle; expectation from the requirements (R3 index, R4 hit, R6/R7 select).
    task automatic step(input logic [K*S-1:0] st, input logic [K-1:0] pm,
                        input logic pv, input int pid,
                        input logic we, input int wa, input logic wv,
                        input logic [K*S-1:0] wst, input int wid, input string req);
        logic [S-1:0] idx;
        logic hit;
        @(negedge clk);
        lkp_state = st; lkp_pm = pm; prev_vld = pv; prev_id = pid[IW-1:0];
        wr_en = we; wr_addr = wa[S-1:0]; wr_valid = wv; wr_states = wst; wr_id = wid[IW-1:0];
        idx = '0;
        for (int i = 0; i < K; i++) idx = idx ^ st[i*S +: S];
        hit = (&pm) && m_valid[idx] && (m_states[idx] == st);
        exp_vld_q.push_back(hit || pv);
        exp_id_q.push_back(hit ? m_id[idx] : (pv ? pid[IW-1:0] : '0));
        req_q.push_back(req);
        if (we) begin
            m_valid[wa] = wv; m_states[wa] = wst; m_id[wa] = wid[IW-1:0];
        end
    endtask

    task automatic look(input logic [K*S-1:0] st, input logic [K-1:0] pm,
                        input logic pv, input int pid, input string req);
        step(st, pm, pv, pid, 1'b0, 0, 1'b0, '0, 0, req);
    endtask

    task automatic put(input int wa, input logic wv, input logic [K*S-1:0] wst,
                       input int wid, input string req);
        step('0, '0, 1'b0, 0, 1'b1, wa, wv, wst, wid, req);
    endtask

    // Monitor: one result per posedge after each driven cycle.
    always @(posedge clk) begin
        #1;
        if (exp_vld_q.size() > 0) begin
            logic ev;
            logic [IW-1:0] ei;
            string r;
            ev = exp_vld_q.pop_front();
            ei = exp_id_q.pop_front();
            r  = req_q.pop_front();
            checks++;
            if (match_vld !== ev || match_id !== ei) begin
                errors++;
                $display("FAIL %s: got vld=%0b id=%0d, expected vld=%0b id=%0d",
                         r, match_vld, match_id, ev, ei);
            end
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_states[i] = '0; m_id[i] = '0;
        end
        repeat (3) @(negedge clk);
        checks++;
        if (match_vld !== 1'b0 || match_id !== '0) begin
            errors++;
            $display("FAIL R1: reset output vld=%0b id=%0d, expected 0 0", match_vld, match_id);
        end
        rst_n = 1'b1;
        // R1: empty table after reset, full flags
        look(tup(1,2,3), 3'b111, 1'b0, 0, "R1");
        // R8: write entry at index 1^2^3=0 with a same-cycle lookup (old contents)
        step(tup(1,2,3), 3'b111, 1'b0, 0, 1'b1, 0, 1'b1, tup(1,2,3), 5, "R8");
        // R4: hit on the next cycle
        look(tup(1,2,3), 3'b111, 1'b0, 0, "R4");
        // R2: one flag clear, no hit
        look(tup(1,2,3), 3'b101, 1'b0, 0, "R2");
        look(tup(1,2,3), 3'b011, 1'b1, 17, "R2");
        // R3: second entry at 4^5^6=7
        put(7, 1'b1, tup(4,5,6), 9, "R3");
        look(tup(4,5,6), 3'b111, 1'b0, 0, "R3");
        // R5: invalid slot (4^5^7=6) and tag mismatch on same index (5,4,6)
        look(tup(4,5,7), 3'b111, 1'b0, 0, "R5");
        look(tup(5,4,6), 3'b111, 1'b0, 0, "R5");
        // R7: mismatch with an arriving match
        look(tup(5,4,6), 3'b111, 1'b1, 3, "R7");
        look('0, 3'b000, 1'b1, 63, "R7");
        // R6: local hit beats arriving match
        look(tup(4,5,6), 3'b111, 1'b1, 22, "R6");
        look(tup(1,2,3), 3'b111, 1'b1, 40, "R6");
        // back-to-back alternating hits
        look(tup(4,5,6), 3'b111, 1'b0, 0, "R4");
        look(tup(1,2,3), 3'b111, 1'b0, 0, "R4");
        // R8: invalidate index 7
        put(7, 1'b0, tup(4,5,6), 9, "R8");
        look(tup(4,5,6), 3'b111, 1'b0, 0, "R8");
        look(tup(4,5,6), 3'b111, 1'b1, 12, "R8");
        // R8: overwrite index 0 with a new id
        put(0, 1'b1, tup(1,2,3), 33, "R8");
        look(tup(1,2,3), 3'b111, 1'b0, 0, "R8");
        look('0, 3'b000, 1'b0, 0, "R5");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule